// File: doc/BRIEF.md
# Transmitter power-up sequencing controller

The controller holds a power management configuration written as a 16-bit command word and turns it into enable lines for the oscillator, frequency synthesizer, power amplifier, low-battery detector, wake-up timer and clock output buffer. Each of these blocks can be switched on directly by its own configuration bit. The oscillator, synthesizer and amplifier can also be brought up by the controller itself when a transmission is requested.

In automatic mode a transmit-start strobe first switches on the oscillator. The synthesizer follows once the oscillator reports a stable reference. The amplifier follows after a fixed PLL settling delay. A transmission ends in one of two ways. If a byte count was supplied with the start strobe, the amplifier drops after that many bytes. With no count (host-driven mode), everything the sequencer switched on stays up until a sleep strobe. Peripheral events also force the oscillator on. With the clock buffer enabled, that request is held until the next sleep strobe.

All enables are registered. An input seen at one rising edge shows on the enables at the next rising edge. A configuration write therefore appears at the second edge after the write cycle.

Top module: `txpwr_seq`

## Requirements
- R1: A write is accepted only when `cmd_word[15:8]` equals 8'hC0. Any other header leaves the configuration and all enables unchanged.
- R2: Reset loads the configuration 16'hC000. After reset every enable is low, except `en_clkout`, which is high.
- R3: Bit 5 drives `en_osc`, bit 4 `en_synth`, bit 3 `en_pa`, bit 2 `en_lbd` and bit 1 `en_wkt`. Bit 0 set drives `en_clkout` low. All of these change at the second rising edge after the write cycle.
- R4: With bit 7 (auto) set, a `tx_start` seen in idle raises `en_osc`. `en_synth` rises only after `osc_stable` has been seen high in the waiting state.
- R5: After the synthesizer is started, the sequencer waits LOCK_CYCLES cycles. It then raises `en_pa`, but only if bit 6 is set.
- R6: A direct enable bit keeps its block on at all times. Automatic control only adds to it (logical OR).
- R7: A nonzero `tx_len` is captured at start. After that many `byte_sent` pulses in the running state, the automatic amplifier enable drops, while the oscillator and synthesizer stay on.
- R8: With `tx_len` zero, `byte_sent` has no effect. A `sleep` pulse clears all automatic enables and returns the sequencer to idle, and the directly written bits are kept.
- R9: `tx_start` is ignored while a sequence is running, and also when bit 7 is clear.
- R10: A `periph_evt` pulse forces `en_osc` on. If bit 0 was clear, the oscillator stays on until `sleep`. If bit 0 was set, it stays on for one cycle only.
- R11: When `sleep` and `tx_start` arrive in the same cycle, `sleep` wins and no sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Configuration write strobe |
| cmd_word | input | 16 | Command word, with the header in bits 15..8 |
| tx_start | input | 1 | Transmit-start strobe |
| tx_len | input | LEN_W | Byte count for the transmission, 0 means host-driven |
| byte_sent | input | 1 | Pulse for each transmitted byte |
| sleep | input | 1 | Sleep strobe |
| osc_stable | input | 1 | Oscillator reference is stable |
| periph_evt | input | 1 | Peripheral event request |
| en_osc | output | 1 | Oscillator enable |
| en_synth | output | 1 | Synthesizer enable |
| en_pa | output | 1 | Power amplifier enable |
| en_lbd | output | 1 | Low-battery detector enable |
| en_wkt | output | 1 | Wake-up timer enable |
| en_clkout | output | 1 | Clock output buffer enable |

## Verification
The bench starts the synthesizer only after a delayed `osc_stable`. A design that skipped this wait would raise `en_synth` too early. The PLL delay is counted exactly, so an off-by-one counter moves the rising edge of `en_pa`.

Byte-count mode is driven with the exact number of pulses. Host-driven mode gets stray `byte_sent` pulses, which a design mixing up the two modes would let cut the amplifier. The bench also issues a second start while busy, a start with auto clear, and sleep together with start; a wrong priority leaves a sequence running.

Peripheral events are applied with bit 0 both clear and set. This exposes a hold that is missing or one that never releases. Malformed headers are written to catch a register that accepts any word.

// File: rtl/txpwr_pkg.sv
package txpwr_pkg;
  localparam logic [7:0] CMD_HDR = 8'hC0;

  // field order fixed by the command word: bits 7..0
  typedef struct packed {
    logic auto_seq;   // 7
    logic auto_pa;    // 6
    logic ex;         // 5
    logic es;         // 4
    logic ea;         // 3
    logic eb;         // 2
    logic et;         // 1
    logic dc;         // 0
  } pm_cfg_t;

  localparam pm_cfg_t CFG_RST = '0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OSC,
    ST_LOCK,
    ST_RUN,
    ST_TAIL
  } seq_st_t;
endpackage

// File: rtl/txpwr_cmd_reg.sv
module txpwr_cmd_reg
  import txpwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] word,
  output pm_cfg_t     cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RST;
    end else if (wr && (word[15:8] == CMD_HDR)) begin
      cfg <= pm_cfg_t'(word[7:0]);
    end
  end
endmodule

// File: rtl/txpwr_evt_hold.sv
module txpwr_evt_hold (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic dc,
  input  logic sleep,
  output logic evt_q,
  output logic hold_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      evt_q <= evt;
      if (sleep) begin
        hold_q <= 1'b0;
      end else if (evt && !dc) begin
        hold_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txpwr_seq_fsm.sv
module txpwr_seq_fsm
  import txpwr_pkg::*;
#(
  parameter int LOCK_CYCLES = 256,
  parameter int LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_start,
  input  logic             sleep,
  input  logic             osc_stable,
  input  logic             byte_sent,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             cfg_auto,
  input  logic             cfg_auto_pa,
  output seq_st_t          st,
  output logic             auto_osc,
  output logic             auto_syn,
  output logic             auto_pa
);
  localparam int LK_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_CYCLES - 1);

  logic [LK_W-1:0]  lk_cnt;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] b_cnt;

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      st       <= ST_IDLE;
      auto_osc <= 1'b0;
      auto_syn <= 1'b0;
      auto_pa  <= 1'b0;
      lk_cnt   <= '0;
      b_cnt    <= '0;
      if (rst) len_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (tx_start && cfg_auto) begin
            st       <= ST_OSC;
            auto_osc <= 1'b1;
            len_q    <= tx_len;
            b_cnt    <= '0;
          end
        end
        ST_OSC: begin
          if (osc_stable) begin
            st       <= ST_LOCK;
            auto_syn <= 1'b1;
            lk_cnt   <= '0;
          end
        end
        ST_LOCK: begin
          if (lk_cnt == LK_LAST) begin
            st      <= ST_RUN;
            auto_pa <= cfg_auto_pa;
          end else begin
            lk_cnt <= lk_cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if ((len_q != '0) && byte_sent) begin
            if (b_cnt == len_q - 1'b1) begin
              st      <= ST_TAIL;
              auto_pa <= 1'b0;
            end else begin
              b_cnt <= b_cnt + 1'b1;
            end
          end
        end
        ST_TAIL: ;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txpwr_seq.sv
module txpwr_seq
  import txpwr_pkg::*;
#(
  parameter int LOCK_CYCLES = 256,
  parameter int LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [15:0]      cmd_word,
  input  logic             tx_start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             byte_sent,
  input  logic             sleep,
  input  logic             osc_stable,
  input  logic             periph_evt,
  output logic             en_osc,
  output logic             en_synth,
  output logic             en_pa,
  output logic             en_lbd,
  output logic             en_wkt,
  output logic             en_clkout
);
  pm_cfg_t cfg;
  seq_st_t st;
  logic    auto_osc, auto_syn, auto_pa;
  logic    evt_q, evt_hold;

  txpwr_cmd_reg u_cfg (
    .clk  (clk),
    .rst  (rst),
    .wr   (cmd_wr),
    .word (cmd_word),
    .cfg  (cfg)
  );

  txpwr_evt_hold u_evt (
    .clk    (clk),
    .rst    (rst),
    .evt    (periph_evt),
    .dc     (cfg.dc),
    .sleep  (sleep),
    .evt_q  (evt_q),
    .hold_q (evt_hold)
  );

  txpwr_seq_fsm #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .LEN_W       (LEN_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tx_start    (tx_start),
    .sleep       (sleep),
    .osc_stable  (osc_stable),
    .byte_sent   (byte_sent),
    .tx_len      (tx_len),
    .cfg_auto    (cfg.auto_seq),
    .cfg_auto_pa (cfg.auto_pa),
    .st          (st),
    .auto_osc    (auto_osc),
    .auto_syn    (auto_syn),
    .auto_pa     (auto_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_osc    <= 1'b0;
      en_synth  <= 1'b0;
      en_pa     <= 1'b0;
      en_lbd    <= 1'b0;
      en_wkt    <= 1'b0;
      en_clkout <= 1'b1;
    end else begin
      en_osc    <= cfg.ex | auto_osc | evt_q | evt_hold;
      en_synth  <= cfg.es | auto_syn;
      en_pa     <= cfg.ea | auto_pa;
      en_lbd    <= cfg.eb;
      en_wkt    <= cfg.et;
      en_clkout <= ~cfg.dc;
    end
  end
endmodule

// File: rtl/txpwr_seq_chk.sv
module txpwr_seq_chk
  import txpwr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        cmd_wr,
  input logic [15:0] cmd_word,
  input logic        tx_start,
  input logic        sleep,
  input logic        osc_stable,
  input logic        byte_sent,
  input logic        periph_evt,
  input logic        en_osc,
  input pm_cfg_t     cfg,
  input seq_st_t     st,
  input logic        auto_osc,
  input logic        auto_syn,
  input logic        auto_pa
);
  a_r1_bad_header_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_word[15:8] != CMD_HDR) |=> $stable(cfg));

  a_r4_synth_after_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(auto_syn) |-> $past(osc_stable));

  a_r5_pa_needs_synth: assert property (@(posedge clk) disable iff (rst)
    auto_pa |-> auto_syn);

  a_r7_pa_drop_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(auto_pa) |-> ($past(sleep) || $past(byte_sent)));

  a_r8_sleep_clears: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (st == ST_IDLE && !auto_osc && !auto_syn && !auto_pa));

  a_r9_busy_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && !sleep) |=> st != ST_IDLE);

  a_r10_event_osc_on: assert property (@(posedge clk) disable iff (rst)
    periph_evt |-> ##2 en_osc);

  a_r11_sleep_beats_start: assert property (@(posedge clk) disable iff (rst)
    (sleep && tx_start) |=> st == ST_IDLE);
endmodule

bind txpwr_seq txpwr_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_wr     (cmd_wr),
  .cmd_word   (cmd_word),
  .tx_start   (tx_start),
  .sleep      (sleep),
  .osc_stable (osc_stable),
  .byte_sent  (byte_sent),
  .periph_evt (periph_evt),
  .en_osc     (en_osc),
  .cfg        (cfg),
  .st         (st),
  .auto_osc   (auto_osc),
  .auto_syn   (auto_syn),
  .auto_pa    (auto_pa)
);

// File: tb/txpwr_seq_tb.sv
module txpwr_seq_tb_top;
  localparam int LOCK  = 16;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1;
  logic             cmd_wr = 1'b0;
  logic [15:0]      cmd_word = '0;
  logic             tx_start = 1'b0;
  logic [LEN_W-1:0] tx_len = '0;
  logic             byte_sent = 1'b0;
  logic             sleep = 1'b0;
  logic             osc_stable = 1'b0;
  logic             periph_evt = 1'b0;
  logic en_osc, en_synth, en_pa, en_lbd, en_wkt, en_clkout;

  txpwr_seq #(.LOCK_CYCLES(LOCK), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .tx_start(tx_start), .tx_len(tx_len), .byte_sent(byte_sent),
    .sleep(sleep), .osc_stable(osc_stable), .periph_evt(periph_evt),
    .en_osc(en_osc), .en_synth(en_synth), .en_pa(en_pa),
    .en_lbd(en_lbd), .en_wkt(en_wkt), .en_clkout(en_clkout)
  );

  // behavioural reference: bit 7 auto, 6 auto PA, 5..1 direct, 0 clock-off
  logic [7:0] m_w;
  int  m_st, m_cnt, m_bcnt, m_len;   // 0 idle 1 osc 2 lock 3 run 4 tail
  bit  m_ao, m_as, m_ap, m_evq, m_evh;
  logic [5:0] exp_o;
  int  vectors = 0, misses = 0;
  bit  finished = 0;
  string req = "R2";

  function automatic logic [5:0] model_out();
    return {m_w[5] | m_ao | m_evq | m_evh, m_w[4] | m_as, m_w[3] | m_ap,
            m_w[2], m_w[1], ~m_w[0]};
  endfunction

  task automatic model_reset();
    m_w = 8'h00; m_st = 0; m_cnt = 0; m_bcnt = 0; m_len = 0;
    m_ao = 0; m_as = 0; m_ap = 0; m_evq = 0; m_evh = 0;
  endtask

  task automatic model_next();
    logic [7:0] w_old = m_w;
    if (cmd_wr && cmd_word[15:8] == 8'hC0) m_w = cmd_word[7:0];
    if (sleep) m_evh = 0;
    else if (periph_evt && !w_old[0]) m_evh = 1;
    m_evq = periph_evt;
    if (sleep) begin
      m_st = 0; m_ao = 0; m_as = 0; m_ap = 0; m_cnt = 0; m_bcnt = 0;
    end else begin
      case (m_st)
        0: if (tx_start && w_old[7]) begin
             m_st = 1; m_ao = 1; m_len = int'(tx_len); m_bcnt = 0;
           end
        1: if (osc_stable) begin m_st = 2; m_as = 1; m_cnt = 0; end
        2: if (m_cnt == LOCK - 1) begin m_st = 3; m_ap = w_old[6]; end
           else m_cnt++;
        3: if (m_len != 0 && byte_sent) begin
             if (m_bcnt + 1 == m_len) begin m_st = 4; m_ap = 0; end
             else m_bcnt++;
           end
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    if (rst) begin model_reset(); exp_o = model_out(); end
    else begin exp_o = model_out(); model_next(); end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if ({en_osc, en_synth, en_pa, en_lbd, en_wkt, en_clkout} !== exp_o) begin
      misses++;
      $display("FAIL %s: enables %b expected %b (osc,synth,pa,lbd,wkt,clkout)",
               req, {en_osc, en_synth, en_pa, en_lbd, en_wkt, en_clkout}, exp_o);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [15:0] w);
    cmd_wr = 1; cmd_word = w; tick(); cmd_wr = 0; idle(2);
  endtask

  task automatic start(input int len);
    tx_start = 1; tx_len = LEN_W'(len); tick(); tx_start = 0;
  endtask

  task automatic do_sleep();
    sleep = 1; tick(); sleep = 0; idle(2);
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin byte_sent = 1; tick(); byte_sent = 0; tick(); end
  endtask

  task automatic bring_up();
    idle(3);
    osc_stable = 1; tick(); osc_stable = 0;
    idle(LOCK + 3);
  endtask

  initial begin
    @(negedge clk);
    req = "R2"; idle(3); rst = 0; idle(3);
    req = "R1"; wr(16'hA03F); wr(16'hC13E);
    req = "R3"; wr(16'hC03E); wr(16'hC001); wr(16'hC000);
    // host-driven sequence
    req = "R4"; wr(16'hC0C0); start(0); bring_up();
    req = "R9"; start(3); idle(2);
    req = "R8"; bytes(4); idle(3); do_sleep();
    // direct PA bit plus automatic start
    req = "R6"; wr(16'hC0C8); start(2); bring_up(); bytes(2); idle(2);
    wr(16'hC0C0); do_sleep();
    // byte count mode
    req = "R7"; start(3); bring_up(); bytes(2); idle(2); bytes(1); idle(3);
    bytes(2); do_sleep();
    // auto clear: start ignored
    req = "R9"; wr(16'hC040); start(0); idle(3); osc_stable = 1; tick(); osc_stable = 0; idle(3);
    // sleep and start together
    req = "R11"; wr(16'hC0C0); sleep = 1; tx_start = 1; tick(); sleep = 0; tx_start = 0; idle(4);
    // auto without PA
    req = "R5"; wr(16'hC080); start(0); bring_up(); do_sleep();
    // peripheral events
    req = "R10"; wr(16'hC000); periph_evt = 1; tick(); periph_evt = 0; idle(5);
    do_sleep(); wr(16'hC001); periph_evt = 1; tick(); periph_evt = 0; idle(5);
    req = "R2"; rst = 1; idle(2); rst = 0; idle(2);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule